// File: doc/BRIEF.md
# Index Register Address Generator

This block keeps four 16-bit pointer registers and turns each indirect memory access into a byte address. Every pointer is an alias of two adjacent 8-bit general-purpose registers, so software can load or inspect a pointer one byte at a time. It can also step the pointer automatically as part of an access.

Each access supplies a 3-bit mode code and a pointer select. The address appears combinationally on `addr_o` while the access is presented. Any change the mode makes to the pointer is applied on the clock edge that ends the access. Two relative modes form an address from a pointer plus an unsigned 8-bit offset and leave the pointer as it was. The offset is either the immediate or the accumulator byte. A side flag marks the address as an instruction-memory address, for jumps through a pointer, and the address arithmetic is the same in both cases.

Top module: `idx_addr_gen`

## Requirements
- R1: While `rst_ni` is low, all four pointers are cleared to 0x0000.
- R2: Byte slot 2k is the low byte of pointer k and slot 2k+1 is its high byte, for k = 0..3. A write through `wr_en_i`/`wr_slot_i` changes only that byte. `rd_data_o` returns the byte chosen by `rd_slot_i`.
- R3: Mode 0 (keep): `addr_o` equals the selected pointer, and the pointer does not change.
- R4: Mode 1 (post-decrement): `addr_o` equals the selected pointer. On the edge the pointer becomes its old value minus 1, modulo 2^16.
- R5: Mode 2 (post-increment): `addr_o` equals the selected pointer. On the edge the pointer becomes its old value plus 1, modulo 2^16.
- R6: Mode 3 (pre-increment): `addr_o` equals the selected pointer plus 1, modulo 2^16, and the pointer takes that value on the edge.
- R7: Mode 4 (immediate-relative): `addr_o` equals pointer 3 plus the zero-extended `imm_i`, modulo 2^16, whatever `sel_i` is. No pointer changes.
- R8: Mode 5 (accumulator-relative): `addr_o` equals the selected pointer plus the zero-extended `acc_i`, modulo 2^16. No pointer changes.
- R9: Mode codes 6 and 7 give `addr_o` = 0 and change no pointer.
- R10: If a byte write hits either byte of the pointer that an access would update in the same cycle, only the byte write takes effect. The mode update is dropped.
- R11: With `acc_en_i` low, no pointer changes except through byte writes.
- R12: `addr_imem_o` follows `imem_i`, and the address value does not depend on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_en_i | input | 1 | An indirect access is presented this cycle |
| mode_i | input | 3 | Addressing mode code |
| sel_i | input | 2 | Pointer select |
| imm_i | input | 8 | Unsigned immediate offset |
| acc_i | input | 8 | Accumulator byte, used as an unsigned offset |
| imem_i | input | 1 | Access targets instruction memory |
| wr_en_i | input | 1 | General register byte write enable |
| wr_slot_i | input | 3 | Byte slot to write |
| wr_data_i | input | 8 | Byte write data |
| rd_slot_i | input | 3 | Byte slot to read back |
| addr_o | output | 16 | Effective byte address |
| addr_imem_o | output | 1 | Address is an instruction-memory address |
| rd_data_o | output | 8 | Read-back byte |

## Verification
The bench builds the block with its default parameters: four pointers of two 8-bit bytes each. At that size every pointer can be driven to 0x0000 and 0xFFFF through byte writes, so wrap-around in all step and relative modes is reachable directly. Random traffic mixes every mode code with byte writes that land on the accessed pointer. This brings the write-over-update collision and the unused codes into reach many times per run.

// File: rtl/idx_pkg.sv
package idx_pkg;
  typedef enum logic [2:0] {
    M_KEEP   = 3'd0,
    M_PDEC   = 3'd1,
    M_PINC   = 3'd2,
    M_PREINC = 3'd3,
    M_IMMREL = 3'd4,
    M_ACCREL = 3'd5
  } idx_mode_e;
endpackage

// File: rtl/idx_addr_calc.sv
module idx_addr_calc
  import idx_pkg::*;
#(
  parameter int NUM_IDX = 4,
  parameter int BYTE_W  = 8,
  parameter int REL_IDX = NUM_IDX - 1,
  localparam int AW     = 2 * BYTE_W,
  localparam int SEL_W  = $clog2(NUM_IDX)
) (
  input  logic [NUM_IDX-1:0][AW-1:0] idx_i,
  input  logic                       acc_en_i,
  input  logic [2:0]                 mode_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [BYTE_W-1:0]          imm_i,
  input  logic [BYTE_W-1:0]          acc_i,
  output logic [AW-1:0]              addr_o,
  output logic                       upd_en_o,
  output logic [SEL_W-1:0]           upd_sel_o,
  output logic [AW-1:0]              upd_val_o
);
  logic [AW-1:0] base, inc, dec, imm_ext, acc_ext;

  assign base    = idx_i[sel_i];
  assign inc     = base + AW'(1);
  assign dec     = base - AW'(1);
  assign imm_ext = {{(AW-BYTE_W){1'b0}}, imm_i};
  assign acc_ext = {{(AW-BYTE_W){1'b0}}, acc_i};
  assign upd_sel_o = sel_i;

  always_comb begin
    addr_o    = '0;
    upd_en_o  = 1'b0;
    upd_val_o = base;
    case (idx_mode_e'(mode_i))
      M_KEEP:   addr_o = base;
      M_PDEC:   begin addr_o = base; upd_en_o = acc_en_i; upd_val_o = dec; end
      M_PINC:   begin addr_o = base; upd_en_o = acc_en_i; upd_val_o = inc; end
      M_PREINC: begin addr_o = inc;  upd_en_o = acc_en_i; upd_val_o = inc; end
      M_IMMREL: addr_o = idx_i[REL_IDX] + imm_ext;
      M_ACCREL: addr_o = base + acc_ext;
      default:  addr_o = '0;
    endcase
  end
endmodule

// File: rtl/idx_regfile.sv
module idx_regfile #(
  parameter int NUM_IDX = 4,
  parameter int BYTE_W  = 8,
  localparam int AW     = 2 * BYTE_W,
  localparam int SEL_W  = $clog2(NUM_IDX),
  localparam int SLOT_W = $clog2(2 * NUM_IDX)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [SLOT_W-1:0]          wr_slot_i,
  input  logic [BYTE_W-1:0]          wr_data_i,
  input  logic                       upd_en_i,
  input  logic [SEL_W-1:0]           upd_sel_i,
  input  logic [AW-1:0]              upd_val_i,
  input  logic [SLOT_W-1:0]          rd_slot_i,
  output logic [BYTE_W-1:0]          rd_data_o,
  output logic [NUM_IDX-1:0][AW-1:0] idx_o
);
  logic [2*NUM_IDX-1:0][BYTE_W-1:0] bytes;

  for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
    logic hit_lo, hit_hi, upd_me;
    assign hit_lo = wr_en_i && (wr_slot_i == SLOT_W'(2*g));
    assign hit_hi = wr_en_i && (wr_slot_i == SLOT_W'(2*g+1));
    assign upd_me = upd_en_i && (upd_sel_i == SEL_W'(g));

    // a byte write into the pair drops the mode update for that pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     idx_o[g] <= '0;
      else if (hit_lo) idx_o[g][BYTE_W-1:0] <= wr_data_i;
      else if (hit_hi) idx_o[g][AW-1:BYTE_W] <= wr_data_i;
      else if (upd_me) idx_o[g] <= upd_val_i;
    end
  end

  assign bytes     = idx_o;
  assign rd_data_o = bytes[rd_slot_i];
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen #(
  parameter int NUM_IDX = 4,
  parameter int BYTE_W  = 8,
  localparam int AW     = 2 * BYTE_W,
  localparam int SEL_W  = $clog2(NUM_IDX),
  localparam int SLOT_W = $clog2(2 * NUM_IDX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_en_i,
  input  logic [2:0]        mode_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [BYTE_W-1:0] imm_i,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic              imem_i,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [AW-1:0]     addr_o,
  output logic              addr_imem_o,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [NUM_IDX-1:0][AW-1:0] idx_q;
  logic                       upd_en;
  logic [SEL_W-1:0]           upd_sel;
  logic [AW-1:0]              upd_val;

  idx_addr_calc #(.NUM_IDX(NUM_IDX), .BYTE_W(BYTE_W)) i_calc (
    .idx_i(idx_q), .acc_en_i(acc_en_i), .mode_i(mode_i), .sel_i(sel_i),
    .imm_i(imm_i), .acc_i(acc_i), .addr_o(addr_o), .upd_en_o(upd_en),
    .upd_sel_o(upd_sel), .upd_val_o(upd_val)
  );

  idx_regfile #(.NUM_IDX(NUM_IDX), .BYTE_W(BYTE_W)) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_slot_i(wr_slot_i),
    .wr_data_i(wr_data_i), .upd_en_i(upd_en), .upd_sel_i(upd_sel),
    .upd_val_i(upd_val), .rd_slot_i(rd_slot_i), .rd_data_o(rd_data_o),
    .idx_o(idx_q)
  );

  assign addr_imem_o = imem_i;

  a_r3_keep_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i && mode_i == 3'd0 && !wr_en_i |=> $stable(idx_q));
  a_r4_post_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i && mode_i == 3'd1 && !wr_en_i |=>
    idx_q[$past(sel_i)] == $past(idx_q[sel_i]) - AW'(1));
  a_r5_post_inc_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i && mode_i == 3'd2 |-> addr_o == idx_q[sel_i]);
  a_r6_pre_inc_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i && mode_i == 3'd3 |-> addr_o == idx_q[sel_i] + AW'(1));
  a_r7_imm_no_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i && mode_i == 3'd4 && !wr_en_i |=> $stable(idx_q));
  a_r9_bad_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i > 3'd5 |-> addr_o == '0);
  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_en_i && !wr_en_i |=> $stable(idx_q));
endmodule

// File: tb/test_idx_addr_gen.sv
`timescale 1ns/1ps
module test_idx_addr_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_en = 0, imem = 0, wr_en = 0;
  logic [2:0] mode = 0, wr_slot = 0, rd_slot = 0;
  logic [1:0] sel = 0;
  logic [7:0] imm = 0, acc = 0, wr_data = 0, rd_data;
  logic [15:0] addr;
  logic addr_imem;
  int n_run = 0, n_fail = 0;
  int ref_q[4];

  always #2 clk = ~clk;

  idx_addr_gen i_idx_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .acc_en_i(acc_en), .mode_i(mode),
    .sel_i(sel), .imm_i(imm), .acc_i(acc), .imem_i(imem), .wr_en_i(wr_en),
    .wr_slot_i(wr_slot), .wr_data_i(wr_data), .rd_slot_i(rd_slot),
    .addr_o(addr), .addr_imem_o(addr_imem), .rd_data_o(rd_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int rd_byte(input int s);
    return (s % 2) ? (ref_q[s/2] >> 8) & 8'hFF : ref_q[s/2] & 8'hFF;
  endfunction

  string rb_tag = "R1";

  task automatic step(input bit en, input int md, input int sl, input int im,
                      input int ac, input bit we, input int ws, input int wd,
                      input int rs, input bit imf);
    int base, ea, nv; bit upd; string t;
    @(negedge clk);
    acc_en = en; mode = md[2:0]; sel = sl[1:0]; imm = im[7:0]; acc = ac[7:0];
    wr_en = we; wr_slot = ws[2:0]; wr_data = wd[7:0]; rd_slot = rs[2:0]; imem = imf;
    #1;
    chk(rb_tag, rd_data, rd_byte(rs));
    base = ref_q[sl]; upd = 0; nv = base;
    case (md)
      0: begin ea = base; t = "R3"; end
      1: begin ea = base; nv = (base - 1) & 16'hFFFF; upd = 1; t = "R4"; end
      2: begin ea = base; nv = (base + 1) & 16'hFFFF; upd = 1; t = "R5"; end
      3: begin ea = (base + 1) & 16'hFFFF; nv = ea; upd = 1; t = "R6"; end
      4: begin ea = (ref_q[3] + im) & 16'hFFFF; t = "R7"; end
      5: begin ea = (base + ac) & 16'hFFFF; t = "R8"; end
      default: begin ea = 0; t = "R9"; end
    endcase
    chk(t, addr, ea);
    chk("R12", addr_imem, imf);
    @(posedge clk);
    rb_tag = en ? t : (we ? "R2" : "R11");
    if (we) begin
      if (ws % 2) ref_q[ws/2] = (ref_q[ws/2] & 16'h00FF) | (wd << 8);
      else        ref_q[ws/2] = (ref_q[ws/2] & 16'hFF00) | wd;
      if (en && upd && ws/2 == sl) rb_tag = "R10";
    end
    if (en && upd && !(we && ws/2 == sl)) ref_q[sl] = nv;
  endtask

  task automatic load(input int k, input int v);
    step(0, 0, 0, 0, 0, 1, 2*k, v & 8'hFF, 0, 0);
    step(0, 0, 0, 0, 0, 1, 2*k+1, (v >> 8) & 8'hFF, 0, 0);
  endtask

  initial begin
    #(4.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    foreach (ref_q[i]) ref_q[i] = 0;
    #1;
    for (int s = 0; s < 8; s++) begin rd_slot = s[2:0]; #1; chk("R1", rd_data, 0); end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R2 byte map
    for (int k = 0; k < 4; k++) load(k, 16'h1100 * (k + 1) + k);
    rb_tag = "R2";
    for (int s = 0; s < 8; s++) step(0, 0, 0, 0, 0, 0, 0, 0, s, 0);
    // R4/R5/R6 wrap edges
    load(1, 16'h0000);
    step(1, 1, 1, 0, 0, 0, 0, 0, 2, 0);
    step(1, 0, 1, 0, 0, 0, 0, 0, 3, 0);
    load(2, 16'hFFFF);
    step(1, 2, 2, 0, 0, 0, 0, 0, 4, 1);
    step(1, 0, 2, 0, 0, 0, 0, 0, 5, 0);
    load(0, 16'hFFFF);
    step(1, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R7 relative wrap, select ignored
    load(3, 16'hFFF0);
    step(1, 4, 0, 8'hFF, 0, 0, 0, 0, 6, 1);
    step(1, 5, 3, 0, 8'h20, 0, 0, 0, 7, 0);
    // R9 unused codes
    step(1, 6, 1, 5, 5, 0, 0, 0, 2, 0);
    step(1, 7, 2, 5, 5, 0, 0, 0, 4, 0);
    // R10 write wins over update
    step(1, 2, 1, 0, 0, 1, 3, 8'hAB, 2, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 3, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int md = $urandom_range(0, 7);
      int sl = $urandom_range(0, 3);
      bit we = ($urandom_range(0, 3) == 0);
      int ws = we && $urandom_range(0, 1) ? 2*sl + $urandom_range(0, 1) : $urandom_range(0, 7);
      int wd = ($urandom_range(0, 3) == 0) ? 8'hFF : $urandom_range(0, 255);
      step($urandom_range(0, 4) != 0, md, sl, $urandom_range(0, 255),
           $urandom_range(0, 255), we, ws, wd, $urandom_range(0, 7), $urandom_range(0, 1));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule